// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block is a small arithmetic coprocessor that sits behind a byte-wide register write port. Software loads a multiplicand and then writes the second multiplier operand. That write starts an unsigned 8-bit by 8-bit multiply, which runs as one conditional add per clock. For a divide, software loads a 16-bit dividend one byte at a time and then writes an 8-bit divisor. That write starts an unsigned 16-bit by 8-bit restoring divide, which produces one quotient bit per clock, most significant bit first.

Two 16-bit result values are presented continuously. The first holds the quotient. The second is shared: after a multiply it holds the product, and after a divide it holds the remainder. While an operation runs, both result outputs show partial values and `busy` is high. A write that starts an operation while another one is running abandons the old one and begins again from step zero.

There are two resets. The power-on reset sets every register, with the operand registers preset to all-ones. The synchronous soft reset clears the result registers and cancels any operation, but it keeps the stored multiplicand and dividend.

Top module: `muldiv_unit`

## Requirements
- R1: A write with `wr_sel`=1 starts a multiply of stored multiplicand A by `wr_data`. `busy` is high after each of the next 7 rising edges and low after the 8th. After the 8th edge, `prod_rem` equals A*B.
- R2: A write with `wr_sel`=4 starts a divide of the stored dividend by `wr_data`. `busy` is high after each of the next 15 edges and low after the 16th. After the 16th edge, `quotient` equals the floor of the quotient and `prod_rem` equals the remainder.
- R3: `prod_rem` is shared between the product and the remainder. A multiply never changes `quotient`.
- R4: Multiplicand A (`wr_sel`=0) is kept across multiplies, so writing only B again multiplies with the old A.
- R5: Dividing by zero gives `quotient`=16'hFFFF and `prod_rem` equal to the dividend, with the same 16-step latency.
- R6: After power-on reset, `busy`=0 and both results are 0. Multiplicand A is 8'hFF and the dividend is 16'hFFFF. The dividend low byte is written with `wr_sel`=2 and the high byte with `wr_sel`=3.
- R7: When `soft_rst` is high at a clock edge, `busy` goes to 0 and both results go to 0. A and the dividend keep their values. A start that coincides with `soft_rst` is dropped.
- R8: A start issued while an operation is running abandons that operation. The new result appears after the full latency of the new operation, counted from its own start.
- R9: Writing A or the dividend while an operation is running does not change the operation in progress. The new value is used by the next operation.
- R10: Writes with `wr_sel` values 5 to 7 change no operand and no result, and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 A, 1 B/start multiply, 2 dividend low, 3 dividend high, 4 divisor/start divide |
| wr_data | input | 8 | Write data |
| quotient | output | 16 | Quotient result |
| prod_rem | output | 16 | Product or remainder result |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check, on every cycle, the following properties:
- A start raises `busy`, and the final step drops it.
- Multiplicand A changes only when A is written.
- A multiply in progress leaves `quotient` untouched.
- Both results hold while the unit is idle.
- A soft reset returns the unit to idle with cleared results.

Arithmetic correctness needs the bench's sweeps, which compare against products, quotients and remainders computed arithmetically. The bench also covers the following:
- the exact latency;
- divide by zero;
- abort-and-restart;
- mid-operation operand writes;
- the preset operand values.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [2:0] SEL_MCAND_A = 3'd0;
  localparam logic [2:0] SEL_MCAND_B = 3'd1;
  localparam logic [2:0] SEL_DVD_LO  = 3'd2;
  localparam logic [2:0] SEL_DVD_HI  = 3'd3;
  localparam logic [2:0] SEL_DIVISOR = 3'd4;

  localparam int unsigned OPW = 8;

  typedef struct packed {
    logic [2*OPW-1:0] rem;
    logic [2*OPW-1:0] quo;
  } div_state_t;

  // One shift-add step. The low half holds the unconsumed multiplier bits
  // and the high half accumulates the partial product.
  function automatic logic [2*OPW-1:0] mul_step(input logic [2*OPW-1:0] p,
                                                input logic [OPW-1:0]   a);
    logic [OPW:0] sum;
    sum = {1'b0, p[2*OPW-1:OPW]} + {1'b0, a};
    if (p[0]) mul_step = {sum, p[OPW-1:1]};
    else      mul_step = {1'b0, p[2*OPW-1:OPW], p[OPW-1:1]};
  endfunction

  // One restoring-divide step. The next dividend bit is shifted into the
  // partial remainder, and a quotient bit is shifted into the low end.
  function automatic div_state_t div_step(input div_state_t s,
                                          input logic [OPW-1:0] d);
    logic [2*OPW:0] t;
    div_state_t     n;
    t = {s.rem, s.quo[2*OPW-1]};
    if (t >= {{(OPW+1){1'b0}}, d}) begin
      t     = t - {{(OPW+1){1'b0}}, d};
      n.quo = {s.quo[2*OPW-2:0], 1'b1};
    end else begin
      n.quo = {s.quo[2*OPW-2:0], 1'b0};
    end
    n.rem = t[2*OPW-1:0];
    div_step = n;
  endfunction

endpackage

// File: rtl/mdu_operands.sv
module mdu_operands #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           wr_a,
  input  logic           wr_dvd_lo,
  input  logic           wr_dvd_hi,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   opa,
  output logic [2*W-1:0] dvd
);
  // Power-on presets only; the soft reset does not touch these registers.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      opa <= '1;
      dvd <= '1;
    end else begin
      if (wr_a)      opa          <= wr_data;
      if (wr_dvd_lo) dvd[W-1:0]   <= wr_data;
      if (wr_dvd_hi) dvd[2*W-1:W] <= wr_data;
    end
  end
endmodule

// File: rtl/mdu_sequencer.sv
module mdu_sequencer #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic soft_rst,
  input  logic start_mul,
  input  logic start_div,
  output logic busy,
  output logic op_div,
  output logic step_en,
  output logic last_step
);
  localparam int MUL_STEPS = W;
  localparam int DIV_STEPS = 2 * W;
  localparam int CW        = $clog2(DIV_STEPS + 1);

  logic [CW-1:0] cnt;
  logic          start_any;

  assign start_any = start_mul | start_div;
  assign step_en   = busy & ~start_any & ~soft_rst;
  assign last_step = step_en & (cnt == CW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy   <= 1'b0;
      op_div <= 1'b0;
      cnt    <= '0;
    end else if (soft_rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_any) begin
      busy   <= 1'b1;
      op_div <= start_div;
      cnt    <= start_div ? CW'(DIV_STEPS) : CW'(MUL_STEPS);
    end else if (step_en) begin
      cnt <= cnt - CW'(1);
      if (last_step) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import muldiv_pkg::*;
#(
  parameter int W = OPW
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           soft_rst,
  input  logic           start_mul,
  input  logic           start_div,
  input  logic           step_en,
  input  logic           op_div,
  input  logic [W-1:0]   wr_data,
  input  logic [W-1:0]   opa,
  input  logic [2*W-1:0] dvd,
  output logic [2*W-1:0] acc,
  output logic [2*W-1:0] quo
);
  logic [W-1:0] mcand;
  logic [W-1:0] dvsr;
  div_state_t   dnext;

  always_comb dnext = div_step('{rem: acc, quo: quo}, dvsr);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      acc   <= '0;
      quo   <= '0;
      mcand <= '0;
      dvsr  <= '0;
    end else if (soft_rst) begin
      acc <= '0;
      quo <= '0;
    end else if (start_mul) begin
      mcand <= opa;
      acc   <= {{W{1'b0}}, wr_data};
    end else if (start_div) begin
      dvsr <= wr_data;
      acc  <= '0;
      quo  <= dvd;
    end else if (step_en) begin
      if (op_div) begin
        acc <= dnext.rem;
        quo <= dnext.quo;
      end else begin
        acc <= mul_step(acc, mcand);
      end
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  output logic [15:0] quotient,
  output logic [15:0] prod_rem,
  output logic        busy
);
  localparam int W = OPW;

  logic           wr_a, wr_dvd_lo, wr_dvd_hi;
  logic           start_mul, start_div;
  logic           op_div, step_en, last_step;
  logic [W-1:0]   opa;
  logic [2*W-1:0] dvd;

  assign wr_a      = wr_en & (wr_sel == SEL_MCAND_A);
  assign wr_dvd_lo = wr_en & (wr_sel == SEL_DVD_LO);
  assign wr_dvd_hi = wr_en & (wr_sel == SEL_DVD_HI);
  assign start_mul = wr_en & (wr_sel == SEL_MCAND_B) & ~soft_rst;
  assign start_div = wr_en & (wr_sel == SEL_DIVISOR) & ~soft_rst;

  mdu_operands #(.W(W)) u_ops (
    .clk(clk), .por_n(por_n), .wr_a(wr_a), .wr_dvd_lo(wr_dvd_lo),
    .wr_dvd_hi(wr_dvd_hi), .wr_data(wr_data), .opa(opa), .dvd(dvd)
  );

  mdu_sequencer #(.W(W)) u_seq (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .start_mul(start_mul),
    .start_div(start_div), .busy(busy), .op_div(op_div),
    .step_en(step_en), .last_step(last_step)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .start_mul(start_mul),
    .start_div(start_div), .step_en(step_en), .op_div(op_div),
    .wr_data(wr_data), .opa(opa), .dvd(dvd), .acc(prod_rem), .quo(quotient)
  );
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk (
  input logic        clk,
  input logic        por_n,
  input logic        soft_rst,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [15:0] quotient,
  input logic [15:0] prod_rem,
  input logic        busy,
  input logic        start_mul,
  input logic        start_div,
  input logic        last_step,
  input logic        op_div,
  input logic [7:0]  opa
);
  logic start_any;
  assign start_any = start_mul | start_div;

  assert_mul_busy_R1: assert property (@(posedge clk) disable iff (!por_n)
    start_mul |=> busy);

  assert_div_busy_R2: assert property (@(posedge clk) disable iff (!por_n)
    start_div |=> busy);

  assert_last_idle_R2: assert property (@(posedge clk) disable iff (!por_n)
    last_step |=> !busy);

  assert_quot_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !op_div && !start_any && !soft_rst) |=> $stable(quotient));

  assert_opa_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && wr_sel == 3'd0) |=> $stable(opa));

  assert_soft_idle_R7: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!busy && quotient == 16'd0 && prod_rem == 16'd0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!busy && !start_any && !soft_rst) |=> ($stable(quotient) && $stable(prod_rem) && !busy));
endmodule

bind muldiv_unit muldiv_unit_chk chk (
  .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .wr_sel(wr_sel), .quotient(quotient), .prod_rem(prod_rem), .busy(busy),
  .start_mul(start_mul), .start_div(start_div), .last_step(last_step),
  .op_div(op_div), .opa(opa)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [15:0] quotient, prod_rem;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  muldiv_unit dut (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .quotient(quotient),
    .prod_rem(prod_rem), .busy(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_dvd(input logic [15:0] v);
    wr(3'd2, v[7:0]);
    wr(3'd3, v[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    por_n = 1'b1;
    wait_n(1);
    // R6 reset state
    chk("R6 busy", {15'd0, busy}, 16'd0);
    chk("R6 quotient", quotient, 16'd0);
    chk("R6 prod_rem", prod_rem, 16'd0);
    // R6 preset A = FF, and R1 latency
    wr(3'd1, 8'd2);
    wait_n(7);
    chk("R1 busy before 8th edge", {15'd0, busy}, 16'd1);
    wait_n(1);
    chk("R1 busy after 8th edge", {15'd0, busy}, 16'd0);
    chk("R6 preset A product", prod_rem, 16'h01FE);
    // R6 preset dividend = FFFF, and R2 latency
    wr(3'd4, 8'h10);
    wait_n(15);
    chk("R2 busy before 16th edge", {15'd0, busy}, 16'd1);
    wait_n(1);
    chk("R2 busy after 16th edge", {15'd0, busy}, 16'd0);
    chk("R6 preset dividend quotient", quotient, 16'h0FFF);
    chk("R6 preset dividend remainder", prod_rem, 16'h000F);

    // R3: multiply leaves quotient intact
    wr(3'd0, 8'd9);
    wr(3'd1, 8'd11);
    wait_n(8);
    chk("R3 quotient kept by multiply", quotient, 16'h0FFF);
    chk("R3 shared reg holds product", prod_rem, 16'd99);

    // R1/R4 sweep: A written once, B-only writes reuse it
    for (int a = 0; a < 256; a += 17) begin
      wr(3'd0, 8'(a));
      for (int b = 0; b < 256; b++) begin
        wr(3'd1, 8'(b));
        wait_n(8);
        chk("R1 R4 product sweep", prod_rem, 16'(a * b));
      end
    end

    // R2 sweep
    for (int i = 0; i < 42; i++) begin
      int dv;
      dv = (i == 40) ? 0 : (i == 41) ? 65535 : (i * 1657 + 7) % 65536;
      set_dvd(16'(dv));
      for (int d = 1; d < 256; d += 6) begin
        wr(3'd4, 8'(d));
        wait_n(16);
        chk("R2 quotient sweep", quotient, 16'(dv / d));
        chk("R2 remainder sweep", prod_rem, 16'(dv % d));
      end
    end

    // R5 divide by zero
    set_dvd(16'hBEEF);
    wr(3'd4, 8'd0);
    wait_n(15);
    chk("R5 busy during div0", {15'd0, busy}, 16'd1);
    wait_n(1);
    chk("R5 div0 quotient", quotient, 16'hFFFF);
    chk("R5 div0 remainder", prod_rem, 16'hBEEF);

    // R7 soft reset mid-op keeps A and dividend
    wr(3'd0, 8'd13);
    set_dvd(16'd1000);
    wr(3'd1, 8'd7);
    wait_n(3);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R7 busy cleared", {15'd0, busy}, 16'd0);
    chk("R7 quotient cleared", quotient, 16'd0);
    chk("R7 prod_rem cleared", prod_rem, 16'd0);
    wr(3'd1, 8'd5);
    wait_n(8);
    chk("R7 A kept", prod_rem, 16'd65);
    wr(3'd4, 8'd7);
    wait_n(16);
    chk("R7 dividend kept quotient", quotient, 16'd142);
    chk("R7 dividend kept remainder", prod_rem, 16'd6);
    // R7 start coinciding with soft reset is dropped
    @(negedge clk); soft_rst = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'd3;
    @(negedge clk); soft_rst = 1'b0; wr_en = 1'b0;
    chk("R7 start dropped busy", {15'd0, busy}, 16'd0);
    wait_n(8);
    chk("R7 start dropped result", prod_rem, 16'd0);

    // R8 restart: multiply interrupted by divide
    wr(3'd1, 8'd200);
    wait_n(3);
    wr(3'd4, 8'd9);
    wait_n(15);
    chk("R8 busy full new latency", {15'd0, busy}, 16'd1);
    wait_n(1);
    chk("R8 busy done", {15'd0, busy}, 16'd0);
    chk("R8 restart quotient", quotient, 16'd111);
    chk("R8 restart remainder", prod_rem, 16'd1);

    // R9 operand writes mid-op
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd5);
    wr(3'd0, 8'd200);
    wait_n(7);
    chk("R9 product unaffected", prod_rem, 16'd15);
    wr(3'd1, 8'd2);
    wait_n(8);
    chk("R9 new A used next", prod_rem, 16'd400);
    set_dvd(16'd500);
    wr(3'd4, 8'd10);
    set_dvd(16'd77);
    wait_n(14);
    chk("R9 quotient unaffected", quotient, 16'd50);
    chk("R9 remainder unaffected", prod_rem, 16'd0);

    // R10 unused selects
    for (int s = 5; s < 8; s++) begin
      wr(3'(s), 8'hA5);
      chk("R10 no busy", {15'd0, busy}, 16'd0);
      chk("R10 quotient kept", quotient, 16'd50);
      chk("R10 prod_rem kept", prod_rem, 16'd0);
    end
    wr(3'd1, 8'd3);
    wait_n(8);
    chk("R10 A kept", prod_rem, 16'd600);
    wr(3'd4, 8'd10);
    wait_n(16);
    chk("R10 dividend kept", quotient, 16'd7);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule